// File: doc/BRIEF.md
# Lockable Thermal Trip Configuration Registers

This block holds the configuration that an on-die thermal monitor uses to decide when to request an emergency power-down. Boot firmware programs three values through a 32-bit register bus: an 8-bit trip threshold in degrees Celsius, a 32-bit calibration slope for the conversion stage, and an enable for the hardware power-down. Firmware then sets a freeze bit. Once that bit is set, none of these values can change again until the next primary power-on reset. No software write can clear the bit, and neither can the warm reset input.

The bus uses byte addresses. Writes commit on the rising clock edge while the write strobe is high. Read data is combinational from the address. The block compares the converted die temperature with the threshold and registers a power-down request, so the request changes on the clock edge after the condition changes. Both reset inputs are asynchronous and active low, and each is released through its own two-stage synchronizer. The power-on reset clears everything. The warm reset clears only the request flop.

Top module: `thermal_cfg_regs`

## Requirements
- R1: After power-on reset, the threshold (offset 0x0) reads 125, the slope (offset 0x4) reads 0, the freeze register (offset 0x8) reads 0, the control register (offset 0xC) reads 0, and the power-down request is 0.
- R2: The threshold lives in bits [7:0] at offset 0x0. Bits [31:8] always read 0 and discard written data.
- R3: While the block is unfrozen, a write to offset 0x4 stores all 32 bits of the slope, and a read returns them.
- R4: Bit 0 at offset 0x8 is the freeze bit. Writing 1 sets it. Writing 0 never sets it, and no later write of any value clears it. Bits [31:1] read 0.
- R5: While frozen, writes to offsets 0x0, 0x4 and 0xC are discarded, and reads keep returning the stored values.
- R6: Bit 1 at offset 0xC is the power-down enable. All other bits of that register read 0 and discard written data.
- R7: The warm reset does not change the freeze bit, the threshold, the slope or the enable. Only power-on reset returns them to their R1 values, after which writes are accepted again.
- R8: The request output goes to 1 on the clock edge after the enable is 1 and the temperature input is greater than or equal to the threshold (equality trips). It goes to 0 on the edge after that condition ends. The warm reset forces it to 0.
- R9: Writes to any address other than 0x0, 0x4, 0x8 and 0xC have no effect, and reads from such addresses return 0.
- R10: The freeze takes effect on the edge that commits the freeze write. A protected write in the cycle just before it is kept, and a protected write in the cycle just after it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Primary power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Secondary reset, asynchronous, active low; clears only the request |
| bus_addr | input | 8 | Byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cur_temp | input | 8 | Converted die temperature, degrees Celsius |
| shutdown_req | output | 1 | Registered power-down request |

## Verification
A corrupted freeze bit or protected field shows at the ports in the cycle it happens, because reads are combinational. A wrong trip compare shows on `shutdown_req` one edge after the temperature or enable changes. The bench therefore reads back every register after each freeze attempt, warm reset pulse and rejected write. It drives the threshold boundary at one degree below, equal to, and one degree above. A freeze bit that gives way to a write of 0 or to the warm reset therefore appears within a single read.

// File: rtl/thermal_cfg_pkg.sv
package thermal_cfg_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned TEMP_W     = 8;
  localparam int unsigned OFS_LIMIT  = 'h0;
  localparam int unsigned OFS_SLOPE  = 'h4;
  localparam int unsigned OFS_FREEZE = 'h8;
  localparam int unsigned OFS_CTRL   = 'hC;
  localparam int unsigned LIMIT_RST  = 125;
  localparam int unsigned EN_BIT     = 1;

  typedef struct packed {
    logic limit;
    logic slope;
    logic freeze;
    logic ctrl;
  } reg_sel_t;
endpackage

// File: rtl/tcfg_rst_sync.sv
module tcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tcfg_decode.sv
module tcfg_decode
  import thermal_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o,
  output logic              hit_o
);
  always_comb begin
    sel_o.limit  = (addr_i == ADDR_W'(OFS_LIMIT));
    sel_o.slope  = (addr_i == ADDR_W'(OFS_SLOPE));
    sel_o.freeze = (addr_i == ADDR_W'(OFS_FREEZE));
    sel_o.ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
    hit_o        = |sel_o;
  end
endmodule

// File: rtl/tcfg_freeze.sv
module tcfg_freeze (
  input  logic clk,
  input  logic por_n,
  input  logic wr_en_i,
  input  logic sel_i,
  input  logic wbit_i,
  output logic frozen_o
);
  logic frozen_q;
  logic set_en;

  always_comb begin
    set_en = wr_en_i & sel_i & wbit_i & ~frozen_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      frozen_q <= 1'b0;
    else if (set_en) frozen_q <= 1'b1;
  end

  assign frozen_o = frozen_q;

  // R4
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    frozen_q |=> frozen_q);
  // R4
  freeze_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en_i && sel_i && wbit_i) |=> frozen_q);
endmodule

// File: rtl/tcfg_field_bank.sv
module tcfg_field_bank
  import thermal_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en_i,
  input  reg_sel_t          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frozen_i,
  output logic [TEMP_W-1:0] limit_o,
  output logic [DATA_W-1:0] slope_o,
  output logic              trip_en_o
);
  logic [TEMP_W-1:0] limit_q, limit_d;
  logic [DATA_W-1:0] slope_q, slope_d;
  logic              en_q, en_d;
  logic              wr_ok, limit_ce, slope_ce, en_ce;

  always_comb begin
    wr_ok    = wr_en_i & ~frozen_i;
    limit_ce = wr_ok & sel_i.limit;
    slope_ce = wr_ok & sel_i.slope;
    en_ce    = wr_ok & sel_i.ctrl;
    limit_d  = wdata_i[TEMP_W-1:0];
    slope_d  = wdata_i;
    en_d     = wdata_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        limit_q <= TEMP_W'(LIMIT_RST);
    else if (limit_ce) limit_q <= limit_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        slope_q <= '0;
    else if (slope_ce) slope_q <= slope_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign limit_o   = limit_q;
  assign slope_o   = slope_q;
  assign trip_en_o = en_q;

  // R5
  frozen_limit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (frozen_i && wr_en_i && sel_i.limit) |=> $stable(limit_q));
  // R5
  frozen_slope_chk: assert property (@(posedge clk) disable iff (!por_n)
    (frozen_i && wr_en_i && sel_i.slope) |=> $stable(slope_q));
  // R5
  frozen_en_chk: assert property (@(posedge clk) disable iff (!por_n)
    frozen_i |=> $stable(en_q));
endmodule

// File: rtl/tcfg_trip.sv
module tcfg_trip
  import thermal_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] limit_i,
  output logic              req_o
);
  logic req_q, req_d;

  always_comb begin
    req_d = en_i & (temp_i >= limit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  // R8
  trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (temp_i >= limit_i)) |=> req_o);
  // R8
  trip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || (temp_i < limit_i)) |=> !req_o);
endmodule

// File: rtl/thermal_cfg_regs.sv
module thermal_cfg_regs
  import thermal_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TEMP_W-1:0] cur_temp,
  output logic              shutdown_req
);
  logic              por_n, warm_n, trip_rst_n;
  reg_sel_t          sel;
  logic              hit;
  logic              frozen;
  logic [TEMP_W-1:0] limit;
  logic [DATA_W-1:0] slope;
  logic              trip_en;

  tcfg_rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_n(por_rst_n), .srst_n(por_n));
  tcfg_rst_sync #(.STAGES(2)) u_warm_sync (
    .clk(clk), .arst_n(warm_rst_n), .srst_n(warm_n));

  assign trip_rst_n = por_n & warm_n;

  tcfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i(bus_addr), .sel_o(sel), .hit_o(hit));

  tcfg_freeze u_freeze (
    .clk(clk), .por_n(por_n), .wr_en_i(bus_wr_en), .sel_i(sel.freeze),
    .wbit_i(bus_wdata[0]), .frozen_o(frozen));

  tcfg_field_bank u_bank (
    .clk(clk), .por_n(por_n), .wr_en_i(bus_wr_en), .sel_i(sel),
    .wdata_i(bus_wdata), .frozen_i(frozen), .limit_o(limit),
    .slope_o(slope), .trip_en_o(trip_en));

  tcfg_trip u_trip (
    .clk(clk), .rst_n(trip_rst_n), .en_i(trip_en), .temp_i(cur_temp),
    .limit_i(limit), .req_o(shutdown_req));

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel.limit:  bus_rdata = DATA_W'(limit);
      sel.slope:  bus_rdata = slope;
      sel.freeze: bus_rdata = DATA_W'(frozen);
      sel.ctrl:   bus_rdata = DATA_W'(trip_en) << EN_BIT;
      default:    bus_rdata = '0;
    endcase
  end

  // R9
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(sel));
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hit |-> (bus_rdata == '0));
  // R2
  limit_rsvd_chk: assert property (@(posedge clk) disable iff (!por_n)
    sel.limit |-> (bus_rdata[DATA_W-1:TEMP_W] == '0));
  // R6
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!por_n)
    sel.ctrl |-> ($countones(bus_rdata) <= 1 && bus_rdata[0] == 1'b0));
endmodule

// File: tb/thermal_cfg_regs_bench.sv
module thermal_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        por_rst_n = 1'b0;
  logic        warm_rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  cur_temp = '0;
  logic        shutdown_req;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  typedef struct {
    bit          is_req;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  thermal_cfg_regs u_thermal_cfg_regs (
    .clk(clk), .por_rst_n(por_rst_n), .warm_rst_n(warm_rst_n),
    .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cur_temp(cur_temp), .shutdown_req(shutdown_req));

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_req ? {31'b0, shutdown_req} : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d cycles expected<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  // two writes on consecutive cycles
  task automatic wr_pair(input logic [7:0] a0, input logic [31:0] d0,
                         input logic [7:0] a1, input logic [31:0] d1);
    @(posedge clk); #1;
    bus_addr = a0; bus_wdata = d0; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_addr = a1; bus_wdata = d1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a; bus_wr_en = 1'b0;
    it.is_req = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic req_is(input bit e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_req = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic set_temp(input logic [7:0] t);
    @(posedge clk); #1;
    cur_temp = t;
    @(posedge clk); #1;
  endtask

  task automatic all_regs(input logic [31:0] l, input logic [31:0] s,
                          input logic [31:0] f, input logic [31:0] c, input string tag);
    rd(8'h00, l, tag); rd(8'h04, s, tag); rd(8'h08, f, tag); rd(8'h0C, c, tag);
  endtask

  task automatic power_on();
    @(posedge clk); #5;
    por_rst_n = 1'b0; warm_rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5; por_rst_n = 1'b1; warm_rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #105; por_rst_n = 1'b1; warm_rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    all_regs(32'd125, 32'h0, 32'h0, 32'h0, "R1 reset value");
    req_is(1'b0, "R1 request after reset");

    // R2 threshold field and reserved bits
    wr(8'h00, 32'hFFFF_FF50);
    rd(8'h00, 32'h0000_0050, "R2 threshold write");
    // R3 slope full width
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, 32'hDEAD_BEEF, "R3 slope write");
    wr(8'h04, 32'h8000_0001);
    rd(8'h04, 32'h8000_0001, "R3 slope second pattern");
    // R6 enable bit only
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0000_0002, "R6 control reserved bits");
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, 32'h0000_0000, "R6 bit0 ignored");
    wr(8'h0C, 32'h0000_0002);

    // R8 boundary around threshold 0x50
    set_temp(8'h4F); req_is(1'b0, "R8 below threshold");
    set_temp(8'h50); req_is(1'b1, "R8 equal threshold");
    set_temp(8'h51); req_is(1'b1, "R8 above threshold");
    set_temp(8'h4F); req_is(1'b0, "R8 drop below");
    set_temp(8'hFF);
    wr(8'h0C, 32'h0); req_is(1'b0, "R8 disabled no trip");
    wr(8'h0C, 32'h2); req_is(1'b1, "R8 re-enabled trip");

    // R9 unmapped addresses
    wr(8'h14, 32'h0000_0011);
    rd(8'h14, 32'h0, "R9 unmapped read");
    rd(8'h02, 32'h0, "R9 misaligned read");
    wr(8'h01, 32'h0000_0022);
    all_regs(32'h50, 32'h8000_0001, 32'h0, 32'h2, "R9 no side effect");

    // R4 writing zero does not freeze
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R4 write zero");
    wr(8'h08, 32'hFFFF_FFFE);
    rd(8'h08, 32'h0, "R4 upper bits only");

    // R10 slope write just before freeze is kept
    wr_pair(8'h04, 32'h1234_5678, 8'h08, 32'hFFFF_FFFF);
    rd(8'h04, 32'h1234_5678, "R10 write before freeze kept");
    rd(8'h08, 32'h1, "R4 freeze set reserved zero");

    // R10 write just after freeze discarded (pair: freeze again then threshold)
    wr_pair(8'h08, 32'h1, 8'h00, 32'h0000_0010);
    rd(8'h00, 32'h50, "R10 write after freeze dropped");

    // R5 protected writes discarded
    wr(8'h00, 32'h0000_0001);
    wr(8'h04, 32'h0);
    wr(8'h0C, 32'h0);
    all_regs(32'h50, 32'h1234_5678, 32'h1, 32'h2, "R5 frozen fields");
    set_temp(8'h60); req_is(1'b1, "R5 trip still enabled");

    // R4 attempts to clear
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h1, "R4 clear by zero");
    wr(8'h08, 32'hFFFF_FFFE);
    rd(8'h08, 32'h1, "R4 clear by pattern");

    // R7 warm reset pulse
    @(posedge clk); #5; warm_rst_n = 1'b0;
    req_is(1'b0, "R8 warm reset clears request");
    rd(8'h08, 32'h1, "R7 freeze during warm reset");
    @(posedge clk); #5; warm_rst_n = 1'b1;
    repeat (3) @(posedge clk);
    all_regs(32'h50, 32'h1234_5678, 32'h1, 32'h2, "R7 after warm reset");
    req_is(1'b1, "R7 trip back after warm reset");
    wr(8'h00, 32'h0000_0033);
    rd(8'h00, 32'h50, "R7 still frozen after warm reset");

    // R7 power-on reset is the only unfreeze
    power_on();
    all_regs(32'd125, 32'h0, 32'h0, 32'h0, "R7 power-on restores");
    req_is(1'b0, "R1 request after power-on");
    wr(8'h00, 32'h0000_0030);
    rd(8'h00, 32'h30, "R7 writable after power-on");

    wait (exp_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule